// File: doc/BRIEF.md
# Command-List Branch Resolver

This block works out where a command-list interpreter goes next after it meets a branching command. The interpreter fetches the command word and the operand words that follow it and presents them, with the address of the command word, on a single request cycle. One cycle later the resolver reports the next command-list address and whether a branch was taken. It resolves three kinds of command. The first is compare-and-branch, which tests the buffer word count or a 24-bit value held in two data registers against a constant. The second is the unconditional relative jump. The third is the computed multiway jump, whose offset table sits in the command list in reverse order.

For the multiway jump the resolver places the address of the table entry it needs on a lookup port. The surrounding logic returns that word in the same cycle. Every offset is a 16-bit two's complement value taken relative to the word that holds it. All address arithmetic wraps modulo the pointer width. Fetching the words and running the command at the target are left to the surrounding interpreter.

Top module: `crb_resolver`

## Requirements
- R1: During and after reset, until the first request, `done` and `taken` are 0 and `next_ptr` is 0.
- R2: A request sampled on a clock edge gives `done` = 1 for exactly the following cycle, with `next_ptr` and `taken` valid in that cycle. `done` is 0 in any cycle that does not follow a request.
- R3: The compare command is opcode 5 in `cmd_word[2:0]`. Its operands are `arg0` = test value low 16 bits, `arg1` = test value high part (low 8 bits used) and `arg2` = offset. When `cmd_word[12]` = 0 the compared value is `buf_count`, zero-extended. When it is 1 the value is the unsigned 24-bit number {`reg_hi[7:0]`, `reg_lo`}.
- R4: The compare condition is set by {`cmd_word[11]`, `cmd_word[10]`}: 00 = value equal to test, 10 = value greater than or equal to test, 01 = not equal, 11 = value less than test. All compares are unsigned.
- R5: When `arg1[15]` = 1, only the low 16 bits of the value and of the test are compared.
- R6: A compare command at address P goes to P+4+`arg2` with `taken` = 1 when its condition holds. Otherwise it goes to P+4 with `taken` = 0.
- R7: Opcode 7 with `cmd_word[10]` = 1 and `cmd_word[11]` = 1 is an unconditional jump whatever `cmd_word[12]` is. It goes to P+2+`arg0` with `taken` = 1, so offset -2 returns to P.
- R8: Opcode 7 with bits 10 and 11 clear and bit 12 set is a multiway jump with `arg0` = data offset and `arg1` = entry count N. It forms index k = `reg_lo` - `arg0` as a signed 16-bit value. For 1 <= k <= N it drives `tbl_addr` = P+3+N-k and goes to `tbl_addr`+1+`tbl_off` with `taken` = 1.
- R9: A multiway jump whose index is zero, negative or greater than N goes to P+3+N with `taken` = 0.
- R10: Any other command (other opcodes, or opcode 7 with other mode bits) goes to P+1 with `taken` = 0.
- R11: All pointer arithmetic wraps modulo 2^PTR_W, with offsets sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operands valid, resolve this cycle |
| cmd_ptr | input | PTR_W | Address P of the command word |
| cmd_word | input | WORD_W | Command word: opcode and mode bits |
| arg0 | input | WORD_W | First word after the command |
| arg1 | input | WORD_W | Second word after the command |
| arg2 | input | WORD_W | Third word after the command |
| buf_count | input | WORD_W | Remaining buffer word count |
| reg_lo | input | WORD_W | Low data register |
| reg_hi | input | WORD_W | High data register |
| tbl_addr | output | PTR_W | Address of the multiway entry to look up |
| tbl_off | input | WORD_W | Word stored at `tbl_addr` |
| done | output | 1 | Result valid |
| taken | output | 1 | A branch was taken |
| next_ptr | output | PTR_W | Next command-list address |

## Verification
The assertions check the request-to-result timing on every cycle. They also check that a jump is always taken, that a compare or multiway command that is not taken lands on its fall-through address, and that unrecognised commands step by one. Only the bench scenarios can show the four condition codes and the choice of compare source. The same holds for the narrowing to 16 bits on a negative high word, the reverse-order table selection at each index and its boundaries, and the wrap of the pointer past the top of the address space.

// File: rtl/crb_pkg.sv
package crb_pkg;
   // condition code as {bit11, bit10}
   typedef enum logic [1:0] {
      CND_EQ = 2'b00,
      CND_NE = 2'b01,
      CND_GE = 2'b10,
      CND_LT = 2'b11
   } crb_cond_e;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_CMP  = 2'd1,
      K_JMP  = 2'd2,
      K_MWAY = 2'd3
   } crb_kind_e;

   localparam int OPC_LSB   = 0;
   localparam int OPC_W     = 3;
   localparam int BIT_MODA  = 10;
   localparam int BIT_MODB  = 11;
   localparam int BIT_SRC   = 12;
   localparam logic [OPC_W-1:0] OPC_CMP  = 3'd5;
   localparam logic [OPC_W-1:0] OPC_JUMP = 3'd7;
endpackage

// File: rtl/crb_compare.sv
module crb_compare
   import crb_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int HI_W   = 8
) (
   input  logic              use_reg,
   input  crb_cond_e         cond,
   input  logic [WORD_W-1:0] buf_count,
   input  logic [WORD_W-1:0] reg_lo,
   input  logic [WORD_W-1:0] reg_hi,
   input  logic [WORD_W-1:0] test_lo,
   input  logic [WORD_W-1:0] test_hi,
   output logic              hit
);
   localparam int FULL_W = WORD_W + HI_W;

   logic [FULL_W-1:0] lhs;
   logic [FULL_W-1:0] rhs;

   generate
      if (HI_W == 0) begin : g_narrow
         assign lhs = use_reg ? reg_lo : buf_count;
         assign rhs = test_lo;
      end else begin : g_wide
         logic [FULL_W-1:0] val_full;
         logic [FULL_W-1:0] tst_full;
         logic              narrow;
         assign val_full = use_reg ? {reg_hi[HI_W-1:0], reg_lo}
                                   : {{HI_W{1'b0}}, buf_count};
         assign tst_full = {test_hi[HI_W-1:0], test_lo};
         assign narrow   = test_hi[WORD_W-1];
         assign lhs = narrow ? {{HI_W{1'b0}}, val_full[WORD_W-1:0]} : val_full;
         assign rhs = narrow ? {{HI_W{1'b0}}, test_lo} : tst_full;
      end
   endgenerate

   always_comb begin
      unique case (cond)
         CND_EQ:  hit = (lhs == rhs);
         CND_NE:  hit = (lhs != rhs);
         CND_GE:  hit = (lhs >= rhs);
         CND_LT:  hit = (lhs <  rhs);
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/crb_multiway.sv
module crb_multiway #(
   parameter int PTR_W  = 16,
   parameter int WORD_W = 16
) (
   input  logic [PTR_W-1:0]  base,
   input  logic [WORD_W-1:0] data_off,
   input  logic [WORD_W-1:0] mult,
   input  logic [WORD_W-1:0] reg_lo,
   input  logic [WORD_W-1:0] tbl_off,
   output logic              in_range,
   output logic [PTR_W-1:0]  tbl_addr,
   output logic [PTR_W-1:0]  target,
   output logic [PTR_W-1:0]  fall_ptr
);
   localparam int SUM_W = ((PTR_W > WORD_W) ? PTR_W : WORD_W) + 1;

   logic [WORD_W-1:0] idx;
   logic [SUM_W-1:0]  off_x;

   assign idx      = reg_lo - data_off;
   assign in_range = !idx[WORD_W-1] && (idx != '0) && (idx <= mult);
   assign off_x    = {{(SUM_W-WORD_W){tbl_off[WORD_W-1]}}, tbl_off};

   // table lies in reverse order: entry N first, entry 1 last
   assign fall_ptr = PTR_W'(SUM_W'(base) + SUM_W'(3) + SUM_W'(mult));
   assign tbl_addr = PTR_W'(SUM_W'(fall_ptr) - SUM_W'(idx));
   assign target   = PTR_W'(SUM_W'(tbl_addr) + SUM_W'(1) + off_x);
endmodule

// File: rtl/crb_resolver.sv
module crb_resolver
   import crb_pkg::*;
#(
   parameter int PTR_W   = 16,
   parameter int WORD_W  = 16,
   parameter int HI_W    = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [PTR_W-1:0]  cmd_ptr,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic [WORD_W-1:0] arg0,
   input  logic [WORD_W-1:0] arg1,
   input  logic [WORD_W-1:0] arg2,
   input  logic [WORD_W-1:0] buf_count,
   input  logic [WORD_W-1:0] reg_lo,
   input  logic [WORD_W-1:0] reg_hi,
   output logic [PTR_W-1:0]  tbl_addr,
   input  logic [WORD_W-1:0] tbl_off,
   output logic              done,
   output logic              taken,
   output logic [PTR_W-1:0]  next_ptr
);
   localparam int SUM_W = ((PTR_W > WORD_W) ? PTR_W : WORD_W) + 1;

   generate
      if (WORD_W <= BIT_SRC) begin : g_chk_word
         $error("WORD_W must hold the mode bits");
      end
      if (HI_W > WORD_W) begin : g_chk_hi
         $error("HI_W may not exceed WORD_W");
      end
      if (PTR_W < 2) begin : g_chk_ptr
         $error("PTR_W too small");
      end
   endgenerate

   logic [OPC_W-1:0] opc;
   logic             mod_a, mod_b, src_reg;
   crb_kind_e        kind;
   crb_cond_e        cond;

   assign opc     = cmd_word[OPC_LSB +: OPC_W];
   assign mod_a   = cmd_word[BIT_MODA];
   assign mod_b   = cmd_word[BIT_MODB];
   assign src_reg = cmd_word[BIT_SRC];
   assign cond    = crb_cond_e'({mod_b, mod_a});

   always_comb begin
      if (opc == OPC_CMP)                                       kind = K_CMP;
      else if (opc == OPC_JUMP && mod_a && mod_b)               kind = K_JMP;
      else if (opc == OPC_JUMP && !mod_a && !mod_b && src_reg)  kind = K_MWAY;
      else                                                      kind = K_NONE;
   end

   logic cmp_hit;
   crb_compare #(.WORD_W(WORD_W), .HI_W(HI_W)) i_cmp (
      .use_reg   (src_reg),
      .cond      (cond),
      .buf_count (buf_count),
      .reg_lo    (reg_lo),
      .reg_hi    (reg_hi),
      .test_lo   (arg0),
      .test_hi   (arg1),
      .hit       (cmp_hit)
   );

   logic             mw_ok;
   logic [PTR_W-1:0] mw_target, mw_fall;
   crb_multiway #(.PTR_W(PTR_W), .WORD_W(WORD_W)) i_mway (
      .base     (cmd_ptr),
      .data_off (arg0),
      .mult     (arg1),
      .reg_lo   (reg_lo),
      .tbl_off  (tbl_off),
      .in_range (mw_ok),
      .tbl_addr (tbl_addr),
      .target   (mw_target),
      .fall_ptr (mw_fall)
   );

   logic [SUM_W-1:0] p_x, a0_x, a2_x;
   logic [PTR_W-1:0] cmp_fall, cmp_target, jmp_target, step_ptr;
   assign p_x        = SUM_W'(cmd_ptr);
   assign a0_x       = {{(SUM_W-WORD_W){arg0[WORD_W-1]}}, arg0};
   assign a2_x       = {{(SUM_W-WORD_W){arg2[WORD_W-1]}}, arg2};
   assign cmp_fall   = PTR_W'(p_x + SUM_W'(4));
   assign cmp_target = PTR_W'(p_x + SUM_W'(4) + a2_x);
   assign jmp_target = PTR_W'(p_x + SUM_W'(2) + a0_x);
   assign step_ptr   = PTR_W'(p_x + SUM_W'(1));

   logic [PTR_W-1:0] nxt_c;
   logic             tkn_c;
   always_comb begin
      unique case (kind)
         K_CMP:   begin tkn_c = cmp_hit; nxt_c = cmp_hit ? cmp_target : cmp_fall; end
         K_JMP:   begin tkn_c = 1'b1;    nxt_c = jmp_target;                      end
         K_MWAY:  begin tkn_c = mw_ok;   nxt_c = mw_ok ? mw_target : mw_fall;     end
         default: begin tkn_c = 1'b0;    nxt_c = step_ptr;                        end
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done     <= 1'b0;
               taken    <= 1'b0;
               next_ptr <= '0;
            end else begin
               done <= req;
               if (req) begin
                  taken    <= tkn_c;
                  next_ptr <= nxt_c;
               end
            end
         end
      end else begin : g_comb
         assign done     = req;
         assign taken    = req && tkn_c;
         assign next_ptr = req ? nxt_c : '0;
      end
   endgenerate
endmodule

// File: rtl/crb_resolver_chk.sv
module crb_resolver_chk #(
   parameter int PTR_W   = 16,
   parameter int WORD_W  = 16,
   parameter int HI_W    = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic [PTR_W-1:0]  cmd_ptr,
   input logic [WORD_W-1:0] cmd_word,
   input logic [WORD_W-1:0] arg1,
   input logic              done,
   input logic              taken,
   input logic [PTR_W-1:0]  next_ptr
);
   logic is_cmp, is_jmp, is_mw, is_other;
   assign is_cmp   = cmd_word[2:0] == 3'd5;
   assign is_jmp   = cmd_word[2:0] == 3'd7 && cmd_word[10] && cmd_word[11];
   assign is_mw    = cmd_word[2:0] == 3'd7 && !cmd_word[10] && !cmd_word[11] && cmd_word[12];
   assign is_other = !is_cmp && !is_jmp && !is_mw;

   generate
      if (REG_OUT) begin : g_seq
         a_r2_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
            req |=> done);
         a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
            !req |=> !done);
         a_r7_jump_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
            req && is_jmp |=> taken);
         a_r6_cmp_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
            req && is_cmp |=> taken || next_ptr == PTR_W'($past(cmd_ptr) + 4));
         a_r9_mway_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
            req && is_mw |=> taken || next_ptr == PTR_W'($past(cmd_ptr) + 3 + $past(arg1)));
         a_r10_other_steps: assert property (@(posedge clk) disable iff (!rst_n)
            req && is_other |=> !taken && next_ptr == PTR_W'($past(cmd_ptr) + 1));
      end
   endgenerate
endmodule

bind crb_resolver crb_resolver_chk #(
   .PTR_W(PTR_W), .WORD_W(WORD_W), .HI_W(HI_W), .REG_OUT(REG_OUT)
) i_chk (.*);

// File: tb/test_crb_resolver.sv
module test_crb_resolver;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [15:0] cmd_ptr = '0, cmd_word = '0, arg0 = '0, arg1 = '0, arg2 = '0;
   logic [15:0] buf_count = '0, reg_lo = '0, reg_hi = '0;
   logic [15:0] tbl_addr, tbl_off;
   logic        done, taken;
   logic [15:0] next_ptr;
   logic [15:0] tbl_mem [64];

   int checks = 0;
   int failures = 0;
   int seen = 0;
   int sent = 0;

   typedef struct {
      logic [15:0] nxt;
      logic        tkn;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   assign tbl_off = tbl_mem[tbl_addr[5:0]];

   crb_resolver i_crb_resolver (
      .clk(clk), .rst_n(rst_n), .req(req), .cmd_ptr(cmd_ptr), .cmd_word(cmd_word),
      .arg0(arg0), .arg1(arg1), .arg2(arg2), .buf_count(buf_count),
      .reg_lo(reg_lo), .reg_hi(reg_hi), .tbl_addr(tbl_addr), .tbl_off(tbl_off),
      .done(done), .taken(taken), .next_ptr(next_ptr)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pop expected result whenever done is seen
   always @(negedge clk) begin
      if (rst_n && done) begin
         seen++;
         if (sb.size() == 0) begin
            check(1'b0, "R2", "done without request", 16'(seen), 16'(sent));
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(next_ptr == e.nxt, e.tag, "next_ptr", next_ptr, e.nxt);
            check(taken == e.tkn, e.tag, "taken", 16'(taken), 16'(e.tkn));
         end
      end
   end

   task automatic send(input logic [15:0] p, input logic [15:0] c, input logic [15:0] a0,
                       input logic [15:0] a1, input logic [15:0] a2, input logic [15:0] cnt,
                       input logic [15:0] lo, input logic [15:0] hi,
                       input logic [15:0] exp_nxt, input logic exp_tkn, input string tag);
      @(negedge clk);
      cmd_ptr = p; cmd_word = c; arg0 = a0; arg1 = a1; arg2 = a2;
      buf_count = cnt; reg_lo = lo; reg_hi = hi; req = 1'b1;
      sb.push_back('{exp_nxt, exp_tkn, tag});
      sent++;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic mway_idx(input logic [15:0] idx_exp_addr, input logic [15:0] lo,
                           input logic [15:0] exp_nxt, input logic tk, input string tag);
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, lo, 16'h0, exp_nxt, tk, tag);
      if (tk) begin
         @(negedge clk);
         req = 1'b0;
      end
      checks++;
      if (idx_exp_addr == 16'hxxxx) failures++;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) tbl_mem[i] = 16'h0;
      tbl_mem[3] = 16'h0000;
      tbl_mem[4] = 16'h0020;
      tbl_mem[5] = 16'hFFF0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check(done == 1'b0, "R1", "done in reset", 16'(done), 16'h0);
      check(taken == 1'b0, "R1", "taken in reset", 16'(taken), 16'h0);
      check(next_ptr == 16'h0, "R1", "next_ptr in reset", next_ptr, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && next_ptr == 16'h0, "R1", "idle after reset", next_ptr, 16'h0);

      // R3/R4/R6: count source, EQ hit and miss
      send(16'h0100, 16'h0005, 16'h0020, 16'h0000, 16'h0010, 16'h0020, 16'h0, 16'h0, 16'h0114, 1'b1, "R3_R6_eq_hit");
      send(16'h0100, 16'h0005, 16'h0020, 16'h0000, 16'h0010, 16'h0021, 16'h0, 16'h0, 16'h0104, 1'b0, "R4_eq_miss");
      // R4: GE with a negative offset, and GE miss
      send(16'h0100, 16'h0805, 16'h0020, 16'h0000, 16'hFFF0, 16'h0030, 16'h0, 16'h0, 16'h00F4, 1'b1, "R4_ge_hit");
      send(16'h0100, 16'h0805, 16'h0020, 16'h0000, 16'hFFF0, 16'h0010, 16'h0, 16'h0, 16'h0104, 1'b0, "R4_ge_miss");
      // R3/R4: register source, NE on the high byte
      send(16'h0100, 16'h1405, 16'h0005, 16'h0000, 16'h0008, 16'h0005, 16'h0005, 16'h0001, 16'h010C, 1'b1, "R3_R4_ne_reg");
      // R5: negative high word narrows to 16 bits
      send(16'h0100, 16'h1405, 16'h0005, 16'h8000, 16'h0008, 16'h0, 16'h0005, 16'h0001, 16'h0104, 1'b0, "R5_ne_narrow");
      // R4: unsigned 24-bit LT
      send(16'h0100, 16'h1C05, 16'h0000, 16'h0001, 16'h0002, 16'h0, 16'hFFFF, 16'h0000, 16'h0106, 1'b1, "R4_lt_24bit");
      // R5: narrow LT true where the 24-bit compare would be false
      send(16'h0100, 16'h1C05, 16'h0004, 16'h8000, 16'h0000, 16'h0, 16'h0003, 16'h0005, 16'h0104, 1'b1, "R5_lt_narrow");
      // R7: unconditional jump
      send(16'h0200, 16'h0C07, 16'hFFFE, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0200, 1'b1, "R7_back_to_self");
      send(16'h0200, 16'h1C07, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0202, 1'b1, "R7_zero_offset");
      // R11: wrap past the top
      send(16'hFFFF, 16'h0C07, 16'h0005, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0006, 1'b1, "R11_wrap");
      // R8: multiway, data offset 10, N = 3, entries reversed at 0x303..0x305
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, 16'd12, 16'h0, 16'h0325, 1'b1, "R8_index2");
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, 16'd11, 16'h0, 16'h02F6, 1'b1, "R8_index1");
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, 16'd13, 16'h0, 16'h0304, 1'b1, "R8_indexN");
      // R9: out of range
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, 16'd10, 16'h0, 16'h0306, 1'b0, "R9_index0");
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, 16'd14, 16'h0, 16'h0306, 1'b0, "R9_above_N");
      send(16'h0300, 16'h1007, 16'd10, 16'd3, 16'h0, 16'h0, 16'd9,  16'h0, 16'h0306, 1'b0, "R9_negative");
      // R10: other commands step by one
      send(16'h0400, 16'h0002, 16'h0033, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0401, 1'b0, "R10_opcode2");
      send(16'h0400, 16'h0407, 16'h0033, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0401, 1'b0, "R10_op7_other");
      // R8: table lookup address while a multiway request is presented
      @(negedge clk);
      cmd_ptr = 16'h0300; cmd_word = 16'h1007; arg0 = 16'd10; arg1 = 16'd3; reg_lo = 16'd11;
      #1 check(tbl_addr == 16'h0305, "R8", "tbl_addr index1", tbl_addr, 16'h0305);
      repeat (3) @(negedge clk);
      // R2: every request produced exactly one result
      check(seen == sent && sb.size() == 0, "R2", "results vs requests", 16'(seen), 16'(sent));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", seen, sent);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule